// File: doc/BRIEF.md
# Vector Shift-Right Unit with Rounding and Accumulate

This block runs one shift-right-by-immediate operation across all lanes of a vector operand. A lane is 8, 16, 32 or 64 bits wide, and the immediate selects the width. The operation can be signed (arithmetic) or unsigned (logical). Two options can be added to it: a rounding step, which adds half of the last shifted-out weight before the shift, and an accumulate step, which adds the shifted lane to the matching lane of a second operand. The vector is 128 bits, or 64 bits when the upper half is not in use.

An issuing stage presents the source and destination operands, the signedness bit, the width-select bit, a 5-bit operation code and a 7-bit immediate, and pulses `in_valid`. One cycle later the unit returns the lane results with `out_valid` high. For an encoding it does not accept, it raises `out_unalloc` and returns a zero result instead of a computed one.

Top module: `vshr_rnd_acc`

## Requirements
- R1: The immediate is `in_imm[6:3]` (the size field) above `in_imm[2:0]`. The lane width is 8, 16, 32 or 64, chosen by the highest set bit of the size field (bit 0, 1, 2 or 3). The shift amount is twice the lane width minus the 7-bit immediate, which gives a value from 1 to the lane width.
- R2: Operation code 0x00 shifts each lane right. When `in_u`=1 the shift is logical and zeros fill from the top. When `in_u`=0 the shift is arithmetic and copies of the sign bit fill from the top. A shift by the full lane width gives zero in the logical case and a lane of sign bits in the arithmetic case.
- R3: Operation codes 0x04 and 0x06 add 1 << (shift-1) to the source lane before the shift. The sum is one bit wider than the lane (sign-extended or zero-extended), so for 64-bit lanes the carry out of bit 63 reaches the result.
- R4: Operation codes 0x02 and 0x06 add the shifted lane to the matching `in_dst` lane. The add wraps modulo the lane width and does not saturate.
- R5: When `in_q`=1, all 128 bits are processed as lanes. When `in_q`=0, only the low 64 bits are processed and the upper 64 bits of the result are zero.
- R6: `out_unalloc` is set in three cases: the size field is 0000, the size field bit 3 is set while `in_q`=0, or the operation code is not one of 0x00, 0x02, 0x04 or 0x06. When it is set, the result is all zeros.
- R7: The result and the flag appear one cycle after an `in_valid` pulse, with `out_valid` high for exactly that cycle. Without `in_valid`, `out_valid` and `out_unalloc` are low and the result holds its value. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_q | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| in_u | input | 1 | 1: unsigned, 0: signed |
| in_opc | input | 5 | Operation code |
| in_imm | input | 7 | Size field over fraction field of the immediate |
| in_src | input | 128 | Source vector |
| in_dst | input | 128 | Destination vector, used as accumulate addend |
| out_valid | output | 1 | Result strobe |
| out_unalloc | output | 1 | Encoding rejected |
| out_res | output | 128 | Result vector |

## Verification
The assertions assume that reset is held low for at least one clock edge, and that every control input is a defined 0 or 1 whenever `in_valid` is high. The hold and latency properties also assume that `in_valid` is a single-cycle strobe sampled on the rising edge. The bench meets these conditions by driving all inputs on the falling edge and raising `in_valid` for one cycle per operation. It keeps the operand fields at known values even between operations.

// File: rtl/vshr_pkg.sv
package vshr_pkg;

    localparam int NUM_SIZES = 4;
    localparam int IMM_W     = 7;
    localparam int OPC_W     = 5;
    localparam int SHAMT_W   = 8;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esz_e;

    localparam logic [OPC_W-1:0] OPC_SHR     = 5'h00;
    localparam logic [OPC_W-1:0] OPC_ACC     = 5'h02;
    localparam logic [OPC_W-1:0] OPC_RND     = 5'h04;
    localparam logic [OPC_W-1:0] OPC_RND_ACC = 5'h06;

    typedef struct packed {
        esz_e               esz;
        logic [SHAMT_W-1:0] shamt;
        logic               rnd;
        logic               acc;
        logic               sgn;
        logic               bad;
    } ctrl_t;

endpackage

// File: rtl/vshr_imm_decode.sv
module vshr_imm_decode
    import vshr_pkg::*;
(
    input  logic             q,
    input  logic             u,
    input  logic [OPC_W-1:0] opc,
    input  logic [IMM_W-1:0] imm,
    output ctrl_t            ctrl
);

    logic [3:0] size_fld;
    logic       op_ok;

    always_comb begin
        size_fld = imm[IMM_W-1:IMM_W-4];

        // highest set bit of the size field picks the lane width
        casez (size_fld)
            4'b1???: ctrl.esz = ESZ_64;
            4'b01??: ctrl.esz = ESZ_32;
            4'b001?: ctrl.esz = ESZ_16;
            default: ctrl.esz = ESZ_8;
        endcase

        // twice the lane width minus the immediate
        ctrl.shamt = (SHAMT_W'(16) << ctrl.esz) - {1'b0, imm};

        ctrl.rnd = (opc == OPC_RND) || (opc == OPC_RND_ACC);
        ctrl.acc = (opc == OPC_ACC) || (opc == OPC_RND_ACC);
        ctrl.sgn = ~u;
        op_ok    = (opc == OPC_SHR) || ctrl.rnd || ctrl.acc;

        ctrl.bad = ~op_ok
                 | (size_fld == 4'b0000)
                 | (size_fld[3] & ~q);
    end

endmodule

// File: rtl/vshr_lane.sv
module vshr_lane #(
    parameter int EW      = 8,
    parameter int SHAMT_W = 8
) (
    input  logic [EW-1:0]      src,
    input  logic [EW-1:0]      dst,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               sgn,
    input  logic               rnd,
    input  logic               acc,
    output logic [EW-1:0]      res
);

    localparam int XW = EW + 1;

    logic        [XW-1:0] ext;
    logic        [XW-1:0] rc;
    logic        [XW-1:0] sum;
    logic signed [XW-1:0] sum_s;
    logic        [XW-1:0] ash;
    logic        [XW-1:0] lsh;
    logic        [EW-1:0] shr;

    always_comb begin
        // one guard bit keeps the rounding carry for the shift
        ext   = {sgn & src[EW-1], src};
        rc    = rnd ? ({{EW{1'b0}}, 1'b1} << (shamt - SHAMT_W'(1))) : '0;
        sum   = ext + rc;
        sum_s = sum;
        ash   = sum_s >>> shamt;
        lsh   = sum >> shamt;
        shr   = sgn ? ash[EW-1:0] : lsh[EW-1:0];
        res   = acc ? (dst + shr) : shr;
    end

endmodule

// File: rtl/vshr_rnd_acc.sv
module vshr_rnd_acc
    import vshr_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_q,
    input  logic             in_u,
    input  logic [OPC_W-1:0] in_opc,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [VEC_W-1:0] in_src,
    input  logic [VEC_W-1:0] in_dst,
    output logic             out_valid,
    output logic             out_unalloc,
    output logic [VEC_W-1:0] out_res
);

    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             vld;
        logic             unalloc;
        logic [VEC_W-1:0] res;
    } state_t;

    ctrl_t            ctrl;
    logic [VEC_W-1:0] size_res [NUM_SIZES];
    logic [VEC_W-1:0] sel;
    state_t           st_d;
    state_t           st_q;

    vshr_imm_decode u_dec (
        .q    (in_q),
        .u    (in_u),
        .opc  (in_opc),
        .imm  (in_imm),
        .ctrl (ctrl)
    );

    // one bank of lanes per element width; the decoded width picks a bank
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int EW = 8 << s;
        localparam int NL = VEC_W / EW;
        logic [VEC_W-1:0] part;

        for (genvar l = 0; l < NL; l++) begin : g_lane
            vshr_lane #(
                .EW      (EW),
                .SHAMT_W (SHAMT_W)
            ) u_lane (
                .src   (in_src[l*EW +: EW]),
                .dst   (in_dst[l*EW +: EW]),
                .shamt (ctrl.shamt),
                .sgn   (ctrl.sgn),
                .rnd   (ctrl.rnd),
                .acc   (ctrl.acc),
                .res   (part[l*EW +: EW])
            );
        end

        assign size_res[s] = part;
    end

    always_comb begin
        st_d         = st_q;
        st_d.vld     = in_valid;
        st_d.unalloc = 1'b0;
        sel          = size_res[ctrl.esz];
        if (!in_q) begin
            sel[VEC_W-1:HALF_W] = '0;
        end
        if (in_valid) begin
            st_d.unalloc = ctrl.bad;
            st_d.res     = ctrl.bad ? '0 : sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_unalloc = st_q.unalloc;
    assign out_res     = st_q.res;

endmodule

// File: rtl/vshr_rnd_acc_chk.sv
module vshr_rnd_acc_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_q,
    input logic             in_u,
    input logic [4:0]       in_opc,
    input logic [6:0]       in_imm,
    input logic             out_valid,
    input logic             out_unalloc,
    input logic [VEC_W-1:0] out_res
);

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res));

    p_unalloc_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_unalloc |-> (out_valid && out_res == '0));

    p_wide_needs_q_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_imm[6] && !in_q) |=> out_unalloc);

    p_no_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_imm[6:3] == 4'b0000) |=> out_unalloc);

    p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_q) |=> (out_res[VEC_W-1:VEC_W/2] == '0));

    p_full_ushr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_q && in_u && in_opc == 5'h00 && in_imm == 7'h40)
        |=> (out_res == '0));

endmodule

bind vshr_rnd_acc vshr_rnd_acc_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_q        (in_q),
    .in_u        (in_u),
    .in_opc      (in_opc),
    .in_imm      (in_imm),
    .out_valid   (out_valid),
    .out_unalloc (out_unalloc),
    .out_res     (out_res)
);

// File: tb/vshr_rnd_acc_bench.sv
`timescale 1ns/1ps
module vshr_rnd_acc_bench;

    localparam int NV = 14;

    typedef struct packed {
        logic [3:0]   req;
        logic         q;
        logic         u;
        logic [4:0]   opc;
        logic [6:0]   imm;
        logic [127:0] src;
        logic [127:0] dst;
        logic         bad;
        logic [127:0] exp;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        // R2: unsigned 8-bit, shift 1
        '{4'd2, 1'b1, 1'b1, 5'h00, 7'h0F, {16{8'h81}}, 128'h0, 1'b0, {16{8'h40}}},
        // R2: signed 8-bit, shift 1
        '{4'd2, 1'b1, 1'b0, 5'h00, 7'h0F, {16{8'h81}}, 128'h0, 1'b0, {16{8'hC0}}},
        // R2: signed 16-bit, full-width shift gives sign bits
        '{4'd2, 1'b1, 1'b0, 5'h00, 7'h10, {8{16'h8001}}, 128'h0, 1'b0, {128{1'b1}}},
        // R2: unsigned 64-bit, full-width shift gives zero
        '{4'd2, 1'b1, 1'b1, 5'h00, 7'h40, {128{1'b1}}, 128'h0, 1'b0, 128'h0},
        // R3: unsigned 64-bit round, shift 64, carry out of bit 63
        '{4'd3, 1'b1, 1'b1, 5'h04, 7'h40, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
          128'h0, 1'b0, {64'h1, 64'h1}},
        // R3: signed 32-bit round, shift 4
        '{4'd3, 1'b1, 1'b0, 5'h04, 7'h3C,
          {32'h0000_0018, 32'hFFFF_FFF8, 32'h7FFF_FFF8, 32'h0000_0017}, 128'h0, 1'b0,
          {32'h0000_0002, 32'h0000_0000, 32'h0800_0000, 32'h0000_0001}},
        // R3: signed 64-bit round, shift 1, positive overflow kept in guard bit
        '{4'd3, 1'b1, 1'b0, 5'h04, 7'h7F, {64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF},
          128'h0, 1'b0, {64'h0, 64'h4000_0000_0000_0000}},
        // R4: unsigned 16-bit accumulate, shift 8, wraps
        '{4'd4, 1'b1, 1'b1, 5'h02, 7'h18, {8{16'hAB00}}, {8{16'hFFF0}}, 1'b0, {8{16'h009B}}},
        // R4: signed 8-bit round and accumulate, shift 2
        '{4'd4, 1'b1, 1'b0, 5'h06, 7'h0E, {16{8'h87}}, {16{8'h10}}, 1'b0, {16{8'hF2}}},
        // R5: 64-bit vector, upper half cleared
        '{4'd5, 1'b0, 1'b1, 5'h00, 7'h0C, {128{1'b1}}, 128'h0, 1'b0, {64'h0, {8{8'h0F}}}},
        // R6: 64-bit lanes with 64-bit vector rejected
        '{4'd6, 1'b0, 1'b1, 5'h00, 7'h40, {128{1'b1}}, 128'h0, 1'b1, 128'h0},
        // R6: empty size field rejected
        '{4'd6, 1'b1, 1'b1, 5'h00, 7'h05, {128{1'b1}}, 128'h0, 1'b1, 128'h0},
        // R6: operation code outside the set rejected
        '{4'd6, 1'b1, 1'b1, 5'h0A, 7'h0F, {128{1'b1}}, 128'h0, 1'b1, 128'h0},
        // R1: size field 0101 selects 32-bit lanes, shift 24
        '{4'd1, 1'b1, 1'b1, 5'h00, 7'h28, {4{32'hAB00_0000}}, 128'h0, 1'b0, {4{32'h0000_00AB}}}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_q = 1'b0;
    logic         in_u = 1'b0;
    logic [4:0]   in_opc = '0;
    logic [6:0]   in_imm = '0;
    logic [127:0] in_src = '0;
    logic [127:0] in_dst = '0;
    logic         out_valid;
    logic         out_unalloc;
    logic [127:0] out_res;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vshr_rnd_acc u_vshr_rnd_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_q        (in_q),
        .in_u        (in_u),
        .in_opc      (in_opc),
        .in_imm      (in_imm),
        .in_src      (in_src),
        .in_dst      (in_dst),
        .out_valid   (out_valid),
        .out_unalloc (out_unalloc),
        .out_res     (out_res)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        in_q     = v.q;
        in_u     = v.u;
        in_opc   = v.opc;
        in_imm   = v.imm;
        in_src   = v.src;
        in_dst   = v.dst;
        in_valid = 1'b1;
    endtask

    task automatic result(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        check({tag, " R7 valid"}, {127'h0, out_valid}, 128'h1);
        check({tag, " R6 flag"},  {127'h0, out_unalloc}, {127'h0, v.bad});
        check({tag, " result"},   out_res, v.exp);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset valid", {127'h0, out_valid}, 128'h0);
        check("R7 reset flag", {127'h0, out_unalloc}, 128'h0);
        check("R7 reset result", out_res, 128'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            in_valid = 1'b0;
            result(TBL[i]);
        end

        // R7: no strobe, result holds and valid stays low
        @(negedge clk);
        check("R7 idle valid", {127'h0, out_valid}, 128'h0);
        check("R7 idle hold", out_res, TBL[NV-1].exp);

        // R7: back-to-back strobes, each result one cycle later
        drive(TBL[5]);
        @(negedge clk);
        in_imm   = TBL[7].imm;
        in_opc   = TBL[7].opc;
        in_u     = TBL[7].u;
        in_q     = TBL[7].q;
        in_src   = TBL[7].src;
        in_dst   = TBL[7].dst;
        result(TBL[5]);
        @(negedge clk);
        in_valid = 1'b0;
        result(TBL[7]);

        // R6: rejected encoding clears a previously held result, flag drops after
        drive(TBL[11]);
        @(negedge clk);
        in_valid = 1'b0;
        result(TBL[11]);
        @(negedge clk);
        check("R6 flag low when idle", {127'h0, out_unalloc}, 128'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule